// File: doc/BRIEF.md
# Packed Eight-Channel Frame Serializer

The block is the clock master of a packed serial audio link. It moves eight playback words in and two capture words out, all within one 256-bit-clock frame. From its master clock it generates a bit clock and a frame clock. One input data pin carries eight 32-bit slots per frame. The block shifts each slot's 24-bit word into a staging register. When the eighth word has been received, it publishes all eight words on a parallel bus and pulses a one-cycle strobe.

On the outgoing pin the block sends a left capture word in the first slot and a right capture word in the fifth slot. Every other bit is driven low. The frame clock is low during the four left-channel slots and high during the four right-channel slots. Only the base-rate master configuration is supported.

The bit clock toggles once every `HALF_DIV` master-clock cycles. With the default `HALF_DIV = 1`, the master clock runs at twice the bit rate and one bit lasts two master cycles.

Top module: `pkf_packed_frame`

## Requirements
- R1: While `rst_ni` is low: `bclk_o` is high, `fclk_o` is high, `sdata_o` is low, `frame_done_o` is low and `dac_o` is all zeros.
- R2: `bclk_o` toggles every `HALF_DIV` master cycles. A frame is exactly `SLOTS*SLOT_BITS` = 256 bit clocks, where bit 0 starts at a falling bit-clock edge.
- R3: `fclk_o` is low for frame bits 0..127 (slots 0..3) and high for bits 128..255 (slots 4..7). It changes only together with a falling edge of `bclk_o`.
- R4: Input slot k (bits 32k..32k+31) carries playback word k MSB first in its first 24 bits. The block samples on the rising `bclk_o` edge. Word k appears at `dac_o[24k +: 24]`. The 8 trailing bits of each slot have no effect on `dac_o`.
- R5: `frame_done_o` is high for exactly one master cycle, right after the rising edge that samples frame bit 247 (the last data bit of slot 7). `dac_o` changes only in that cycle and holds its value otherwise.
- R6: Output bits are launched on the falling `bclk_o` edge. Bits 0..23 carry the left capture word MSB first, and bits 128..151 carry the right capture word MSB first.
- R7: `sdata_o` is low in the 8 trailing bits of every slot and in all of slots 1, 2, 3, 5, 6 and 7.
- R8: `adc_l_i` and `adc_r_i` are captured at the falling edge that starts frame bit 0. Changes to them later in the frame do not alter that frame's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Frame clock, low for the left half and high for the right half |
| sdata_i | input | 1 | Packed playback data, eight slots per frame |
| sdata_o | output | 1 | Packed capture data |
| adc_l_i | input | 24 | Left capture word to send |
| adc_r_i | input | 24 | Right capture word to send |
| dac_o | output | 192 | Eight received words, word k at bits 24k+23..24k |
| frame_done_o | output | 1 | One-cycle pulse when all eight words have been published |

## Verification
The bench tests the slot boundaries with several kinds of input pattern: all ones, a walking one, a walking zero and hashed words. Pad bits are driven high throughout. A deserializer with an off-by-one slot position would take a pad bit into the word, or lose the MSB. A design that let pad bits through would corrupt words in the walking-pattern frames.

The bench changes the capture inputs in the middle of every frame. A transmitter that failed to latch at frame start would send mixed words.

The strobe is checked at its exact cycle on every sample. The frame clock is checked for its level at each bit, and it must not move between falling edges. A swapped half or a misplaced strobe is therefore reported at the first bit where it goes wrong.

// File: rtl/pkf_pkg.sv
package pkf_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } bclk_evt_t;
endpackage

// File: rtl/pkf_clk_gen.sv
module pkf_clk_gen #(
  parameter int HALF_DIV   = 1,
  parameter int FRAME_BITS = 256,
  localparam int CW = $clog2(FRAME_BITS),
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output pkf_pkg::bclk_evt_t  evt_o,
  output logic                bclk_o,
  output logic                fclk_o,
  output logic [CW-1:0]       bit_o,
  output logic [CW-1:0]       bit_nxt_o
);
  logic [DW-1:0] div_q;
  logic          bclk_q;
  logic [CW-1:0] bit_q;
  logic          tick;

  assign tick = (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      bclk_q <= 1'b1;
      bit_q  <= '1;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) bclk_q <= ~bclk_q;
      if (tick && bclk_q) bit_q <= bit_q + 1'b1;
    end
  end

  assign evt_o.fall = tick & bclk_q;
  assign evt_o.rise = tick & ~bclk_q;
  assign bclk_o     = bclk_q;
  assign fclk_o     = bit_q[CW-1];
  assign bit_o      = bit_q;
  assign bit_nxt_o  = bit_q + 1'b1;
endmodule

// File: rtl/pkf_tx.sv
module pkf_tx #(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32,
  parameter int SLOTS     = 8,
  localparam int CW = $clog2(SLOTS * SLOT_BITS),
  localparam int SW = $clog2(SLOTS),
  localparam int PW = $clog2(SLOT_BITS),
  localparam int IW = $clog2(WORD_BITS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fall_i,
  input  logic [CW-1:0]        bit_i,
  input  logic [CW-1:0]        bit_nxt_i,
  input  logic [WORD_BITS-1:0] adc_l_i,
  input  logic [WORD_BITS-1:0] adc_r_i,
  output logic                 sdata_o
);
  logic [WORD_BITS-1:0] l_q, r_q, l_w, r_w;
  logic [SW-1:0]        slot_n;
  logic [PW-1:0]        pos_n;
  logic [IW-1:0]        idx;
  logic                 frame_start, tx_bit;

  assign slot_n      = bit_nxt_i[CW-1 -: SW];
  assign pos_n       = bit_nxt_i[PW-1:0];
  assign frame_start = fall_i && (bit_nxt_i == '0);
  assign l_w         = frame_start ? adc_l_i : l_q;
  assign r_w         = frame_start ? adc_r_i : r_q;
  assign idx         = IW'(WORD_BITS - 1) - IW'(pos_n);

  always_comb begin
    tx_bit = 1'b0;
    if (int'(pos_n) < WORD_BITS) begin
      if (slot_n == '0)                 tx_bit = l_w[idx];
      else if (slot_n == SW'(SLOTS/2))  tx_bit = r_w[idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_q     <= '0;
      r_q     <= '0;
      sdata_o <= 1'b0;
    end else if (fall_i) begin
      l_q     <= l_w;
      r_q     <= r_w;
      sdata_o <= tx_bit;
    end
  end

  // R7
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(bit_i[PW-1:0]) >= WORD_BITS) |-> !sdata_o);
  // R7
  idle_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_i[CW-1 -: SW] != '0 && bit_i[CW-1 -: SW] != SW'(SLOTS/2)) |-> !sdata_o);
endmodule

// File: rtl/pkf_rx.sv
module pkf_rx #(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32,
  parameter int SLOTS     = 8,
  localparam int CW = $clog2(SLOTS * SLOT_BITS),
  localparam int SW = $clog2(SLOTS),
  localparam int PW = $clog2(SLOT_BITS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rise_i,
  input  logic [CW-1:0]              bit_i,
  input  logic                       sdata_i,
  output logic [SLOTS*WORD_BITS-1:0] dac_o,
  output logic                       done_o
);
  logic [WORD_BITS-1:0] shift_q, shift_d;
  logic [WORD_BITS-1:0] stage_q [SLOTS];
  logic [SW-1:0]        slot;
  logic [PW-1:0]        pos;
  logic                 data_bit, word_end, last_slot;

  assign slot      = bit_i[CW-1 -: SW];
  assign pos       = bit_i[PW-1:0];
  assign data_bit  = int'(pos) < WORD_BITS;
  assign word_end  = int'(pos) == WORD_BITS - 1;
  assign last_slot = slot == SW'(SLOTS - 1);
  assign shift_d   = {shift_q[WORD_BITS-2:0], sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      dac_o   <= '0;
      done_o  <= 1'b0;
      for (int k = 0; k < SLOTS; k++) stage_q[k] <= '0;
    end else begin
      done_o <= 1'b0;
      if (rise_i && data_bit) begin
        shift_q <= shift_d;
        if (word_end) begin
          stage_q[slot] <= shift_d;
          if (last_slot) begin
            for (int k = 0; k < SLOTS - 1; k++) dac_o[k*WORD_BITS +: WORD_BITS] <= stage_q[k];
            dac_o[(SLOTS-1)*WORD_BITS +: WORD_BITS] <= shift_d;
            done_o <= 1'b1;
          end
        end
      end
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  dac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_o) |-> done_o);
endmodule

// File: rtl/pkf_packed_frame.sv
module pkf_packed_frame #(
  parameter int HALF_DIV  = 1,
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32,
  parameter int WORD_BITS = 24,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int CW         = $clog2(FRAME_BITS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  output logic                       bclk_o,
  output logic                       fclk_o,
  input  logic                       sdata_i,
  output logic                       sdata_o,
  input  logic [WORD_BITS-1:0]       adc_l_i,
  input  logic [WORD_BITS-1:0]       adc_r_i,
  output logic [SLOTS*WORD_BITS-1:0] dac_o,
  output logic                       frame_done_o
);
  pkf_pkg::bclk_evt_t evt;
  logic [CW-1:0]      bit_cur, bit_nxt;

  pkf_clk_gen #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_o(evt), .bclk_o(bclk_o),
    .fclk_o(fclk_o), .bit_o(bit_cur), .bit_nxt_o(bit_nxt)
  );

  pkf_tx #(.WORD_BITS(WORD_BITS), .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(evt.fall), .bit_i(bit_cur),
    .bit_nxt_i(bit_nxt), .adc_l_i(adc_l_i), .adc_r_i(adc_r_i), .sdata_o(sdata_o)
  );

  pkf_rx #(.WORD_BITS(WORD_BITS), .SLOT_BITS(SLOT_BITS), .SLOTS(SLOTS)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(evt.rise), .bit_i(bit_cur),
    .sdata_i(sdata_i), .dac_o(dac_o), .done_o(frame_done_o)
  );

  // R3
  fclk_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fclk_o) |-> $fell(bclk_o));
  // R5
  done_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> fclk_o);
endmodule

// File: tb/sim_pkf_packed_frame.sv
module sim_pkf_packed_frame;
  logic clk = 0, rst_ni = 0, sdata_i = 0;
  logic bclk_o, fclk_o, sdata_o, frame_done_o;
  logic [23:0] adc_l_i = 0, adc_r_i = 0;
  logic [191:0] dac_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pkf_packed_frame u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bclk_o(bclk_o), .fclk_o(fclk_o),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .adc_l_i(adc_l_i), .adc_r_i(adc_r_i),
    .dac_o(dac_o), .frame_done_o(frame_done_o)
  );

  function automatic logic [23:0] dac_word(int f, int k);
    case (f)
      0: return 24'hFFFFFF;
      1: return 24'h000001 << (k * 3);
      2: return ~(24'h800000 >> (k * 3));
      default: return 24'((f * 32'h9E3779 + k * 32'h01234567) ^ (k << 13));
    endcase
  endfunction

  function automatic logic [23:0] adc_word(int f, int side);
    return 24'((f + 1) * 32'h00A5C3 + side * 32'h5A0F0F + (f << 19));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    int bitn = -1, frame = -1, cyc = 0;
    logic pb, pf;
    logic [23:0] el = 0, er = 0;
    logic [191:0] last = 0, expw;
    bit exp_o;
    repeat (3) @(posedge clk);
    #1;
    chk(bclk_o == 1 && fclk_o == 1 && sdata_o == 0 && frame_done_o == 0, "R1 ctl", {bclk_o, fclk_o, sdata_o, frame_done_o}, 4'b1100);
    chk(dac_o == 0, "R1 dac", dac_o, 0);
    adc_l_i = adc_word(0, 0);
    adc_r_i = adc_word(0, 1);
    pb = bclk_o; pf = fclk_o;
    @(negedge clk) rst_ni = 1;
    while (frame < 6) begin
      @(posedge clk); #1;
      cyc++;
      if (cyc > 20000) begin
        chk(0, "watchdog", 0, 1);
        break;
      end
      chk(bclk_o != pb, "R2 toggle", bclk_o, ~pb);
      if (pb && !bclk_o) begin
        bitn = (bitn + 1) % 256;
        if (bitn == 0) begin
          frame++;
          el = adc_l_i; er = adc_r_i;
          // R2: 256-bit frame boundary coincides with fclk going low
          if (frame > 0) chk(pf == 1 && fclk_o == 0, "R2 frame", fclk_o, 0);
        end
        chk(fclk_o == (bitn >= 128), "R3 level", fclk_o, bitn >= 128);
        exp_o = 0;
        if (bitn % 32 < 24) begin
          if (bitn / 32 == 0) exp_o = el[23 - bitn % 32];
          if (bitn / 32 == 4) exp_o = er[23 - bitn % 32];
        end
        if (bitn / 32 == 0 || bitn / 32 == 4)
          chk(sdata_o == exp_o, (bitn % 32 < 24) ? "R6/R8 data" : "R7 pad", sdata_o, exp_o);
        else
          chk(sdata_o == 0, "R7 idle", sdata_o, 0);
        sdata_i = (bitn % 32 < 24) ? dac_word(frame, bitn / 32)[23 - bitn % 32] : 1'b1;
        if (bitn == 100) begin
          adc_l_i = adc_word(frame + 1, 0);
          adc_r_i = adc_word(frame + 1, 1);
        end
      end else begin
        chk(fclk_o == pf, "R3 stable", fclk_o, pf);
      end
      chk(frame_done_o == (!pb && bclk_o && bitn == 247), "R5 strobe", frame_done_o, !pb && bclk_o && bitn == 247);
      if (frame_done_o) begin
        for (int k = 0; k < 8; k++) expw[k*24 +: 24] = dac_word(frame, k);
        chk(dac_o == expw, "R4 words", dac_o, expw);
        last = dac_o;
      end else begin
        chk(dac_o == last, "R5 hold", dac_o, last);
      end
      pb = bclk_o; pf = fclk_o;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule